// File: doc/BRIEF.md
# Path Delay Test Phase Controller

This block sequences at-speed timing tests over a set of replicated near-critical logic paths. The paths are sorted offline into a fixed number of test phases. A phase-membership parameter says which paths are open in each phase. In every phase the controller pins all paths that are not under test by asserting their Fix control. This holds any shared lookup output constant, so paths that reconverge on it cannot disturb the result. It then launches a deliberate transition on the Edge control of each open path. Because the launched edge is known, the value every open sink register should capture is known exactly.

A run starts with a start pulse. For each phase the controller applies the Fix pattern and waits a parameterised number of settle cycles. It then flips Edge in one cycle, and the path sink registers capture on the following clock edge. In the cycle after that, the controller compares the captured bits against the predicted values with an XNOR. Every phase is exercised first with a rising and then with a falling transition. The phases run in ascending order. A mismatch raises a sticky error flag and records the index of the phase where the first fault was seen. A one-cycle done pulse marks the end of the last phase. There is no data stream, so all pins are plain control and status signals.

Top module: `path_delay_phase_ctrl`

## Requirements
- R1: After reset, busy_o, done_o and error_o are 0, fail_phase_o is 0, every fix_o bit is 1 and every edge_o bit is 0.
- R2: A start_i pulse seen while idle begins a run at phase 0 in the next cycle. A start_i pulse while busy_o is 1 has no effect on the sequence.
- R3: Phases run from 0 to N_PHASES-1 in order. During phase k, fix_o bit p is 0 exactly when bit k*N_PATHS+p of PHASE_MAP is 1 (path p is open), and 1 otherwise.
- R4: Each phase has two passes of SETTLE_CYC+2 cycles each: a rising pass, then a falling pass. In the rising pass the open edge_o bits are 0 for SETTLE_CYC cycles and 1 for the last two cycles. The falling pass is the same with the levels swapped.
- R5: An edge_o bit is 1 only for a path that is open in the current phase. Pinned paths, and all paths while idle, see edge_o 0.
- R6: In the last cycle of each pass, sink_i bit p of every open path is compared against OFFPATH_PAR bit p XOR the level edge_o bit p holds in that cycle. sink_i bits of pinned paths have no effect.
- R7: error_o goes to 1 in the cycle after a compare that finds a mismatch. It stays 1 until a start_i accepted while idle, which clears it in the next cycle.
- R8: fail_phase_o holds the index of the phase in which the first mismatch of the run occurred. Later mismatches do not change it.
- R9: done_o is a single-cycle pulse. It rises, and busy_o falls, in the cycle after the falling-pass compare of the last phase. A run lasts 2*N_PHASES*(SETTLE_CYC+2) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a test run when idle |
| sink_i | input | N_PATHS | Captured sink register bit of each replicated path |
| fix_o | output | N_PATHS | Pin control per path, 1 = output held constant |
| edge_o | output | N_PATHS | Transition control per path |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at end of run |
| error_o | output | 1 | Sticky timing fault flag |
| fail_phase_o | output | max(1,clog2(N_PHASES)) | Phase index of the first fault |

## Verification
The hardest situation to reach is a true timing fault. A path is slow enough that its sink still holds the pre-transition level when it is captured. If that path is open only in a later phase, the error must point at that phase and not at an earlier one. The bench models each replicated path as a chain of pinnable XOR lookups with a one-cycle-late variant selectable per path. This lets it make chosen paths slow. It then runs cases where the slow path is open in the first phase, a middle phase, the last phase, or no phase at all. Between these cases it restarts to show that the error clears.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_LAUNCH,
    ST_CHECK
  } pdt_state_e;

  localparam int MAP_BITS_MAX = 4096;

  // default membership: path p is opened in phase (p mod n_phases)
  function automatic logic [MAP_BITS_MAX-1:0] round_robin_map(int n_phases, int n_paths);
    logic [MAP_BITS_MAX-1:0] m;
    m = '0;
    for (int p = 0; p < n_paths; p++) begin
      int idx;
      idx = (p % n_phases) * n_paths + p;
      if (idx < MAP_BITS_MAX) m[idx] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pdt_phase_table.sv
module pdt_phase_table #(
  parameter int N_PATHS  = 64,
  parameter int N_PHASES = 17,
  parameter logic [N_PHASES*N_PATHS-1:0] PHASE_MAP = '1,
  localparam int PW = (N_PHASES > 1) ? $clog2(N_PHASES) : 1
) (
  input  logic [PW-1:0]      phase_i,
  output logic [N_PATHS-1:0] live_o
);
  always_comb begin
    live_o = PHASE_MAP[int'(phase_i)*N_PATHS +: N_PATHS];
  end
endmodule

// File: rtl/pdt_sequencer.sv
module pdt_sequencer
  import pdt_pkg::*;
#(
  parameter int N_PHASES   = 17,
  parameter int SETTLE_CYC = 4,
  localparam int PW = (N_PHASES > 1) ? $clog2(N_PHASES) : 1,
  localparam int CW = $clog2(SETTLE_CYC) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic [PW-1:0] phase_o,
  output logic          lvl_o,
  output logic          check_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          accept_o
);
  pdt_state_e    st_q;
  logic [PW-1:0] phase_q;
  logic [CW-1:0] cnt_q;
  logic          pass_q;
  logic          lvl_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      phase_q <= '0;
      cnt_q   <= '0;
      pass_q  <= 1'b0;
      lvl_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q    <= ST_SETTLE;
            phase_q <= '0;
            cnt_q   <= '0;
            pass_q  <= 1'b0;
            lvl_q   <= 1'b0;
          end
        end
        ST_SETTLE: begin
          if (cnt_q == CW'(SETTLE_CYC - 1)) begin
            st_q  <= ST_LAUNCH;
            cnt_q <= '0;
            lvl_q <= ~lvl_q;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_LAUNCH: st_q <= ST_CHECK;
        ST_CHECK: begin
          if (!pass_q) begin
            pass_q <= 1'b1;
            st_q   <= ST_SETTLE;
          end else if (phase_q == PW'(N_PHASES - 1)) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            phase_q <= phase_q + 1'b1;
            pass_q  <= 1'b0;
            st_q    <= ST_SETTLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign phase_o  = phase_q;
  assign lvl_o    = lvl_q;
  assign check_o  = (st_q == ST_CHECK);
  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = done_q;
  assign accept_o = start_i && (st_q == ST_IDLE);
endmodule

// File: rtl/pdt_fault_cmp.sv
module pdt_fault_cmp #(
  parameter int N_PATHS  = 64,
  parameter int N_PHASES = 17,
  parameter logic [N_PATHS-1:0] OFFPATH_PAR = '0,
  localparam int PW = (N_PHASES > 1) ? $clog2(N_PHASES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               check_i,
  input  logic               lvl_i,
  input  logic [PW-1:0]      phase_i,
  input  logic [N_PATHS-1:0] live_i,
  input  logic [N_PATHS-1:0] sink_i,
  output logic               error_o,
  output logic [PW-1:0]      fail_phase_o
);
  logic [N_PATHS-1:0] expect_v;
  logic [N_PATHS-1:0] match_v;
  logic               miss;
  logic               err_q;
  logic [PW-1:0]      fph_q;

  always_comb begin
    expect_v = OFFPATH_PAR ^ {N_PATHS{lvl_i}};
    match_v  = ~(sink_i ^ expect_v);
    miss     = |(live_i & ~match_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      fph_q <= '0;
    end else if (clear_i) begin
      err_q <= 1'b0;
      fph_q <= '0;
    end else if (check_i && miss && !err_q) begin
      err_q <= 1'b1;
      fph_q <= phase_i;
    end
  end

  assign error_o      = err_q;
  assign fail_phase_o = fph_q;
endmodule

// File: rtl/path_delay_phase_ctrl.sv
module path_delay_phase_ctrl
  import pdt_pkg::*;
#(
  parameter int N_PATHS    = 64,
  parameter int N_PHASES   = 17,
  parameter int SETTLE_CYC = 4,
  parameter logic [N_PATHS-1:0] OFFPATH_PAR = '0,
  parameter logic [N_PHASES*N_PATHS-1:0] PHASE_MAP =
    (N_PHASES*N_PATHS)'(pdt_pkg::round_robin_map(N_PHASES, N_PATHS))
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [N_PATHS-1:0]  sink_i,
  output logic [N_PATHS-1:0]  fix_o,
  output logic [N_PATHS-1:0]  edge_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                error_o,
  output logic [((N_PHASES > 1) ? $clog2(N_PHASES) : 1)-1:0] fail_phase_o
);
  localparam int PW = (N_PHASES > 1) ? $clog2(N_PHASES) : 1;

  logic [PW-1:0]      phase;
  logic               lvl;
  logic               check;
  logic               accept;
  logic [N_PATHS-1:0] live;

  pdt_sequencer #(
    .N_PHASES  (N_PHASES),
    .SETTLE_CYC(SETTLE_CYC)
  ) i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .phase_o (phase),
    .lvl_o   (lvl),
    .check_o (check),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .accept_o(accept)
  );

  pdt_phase_table #(
    .N_PATHS  (N_PATHS),
    .N_PHASES (N_PHASES),
    .PHASE_MAP(PHASE_MAP)
  ) i_tbl (
    .phase_i(phase),
    .live_o (live)
  );

  pdt_fault_cmp #(
    .N_PATHS    (N_PATHS),
    .N_PHASES   (N_PHASES),
    .OFFPATH_PAR(OFFPATH_PAR)
  ) i_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (accept),
    .check_i     (check),
    .lvl_i       (lvl),
    .phase_i     (phase),
    .live_i      (live),
    .sink_i      (sink_i),
    .error_o     (error_o),
    .fail_phase_o(fail_phase_o)
  );

  always_comb begin
    fix_o  = busy_o ? ~live : '1;
    edge_o = busy_o ? (live & {N_PATHS{lvl}}) : '0;
  end
endmodule

// File: rtl/pdt_checker.sv
module pdt_checker #(
  parameter int N_PATHS  = 64,
  parameter int N_PHASES = 17,
  localparam int PW = (N_PHASES > 1) ? $clog2(N_PHASES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic [N_PATHS-1:0] fix_o,
  input logic [N_PATHS-1:0] edge_o,
  input logic               busy_o,
  input logic               done_o,
  input logic               error_o,
  input logic [PW-1:0]      fail_phase_o
);
  logic accepted;
  assign accepted = start_i && !busy_o;

  AST_IDLE_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> ((&fix_o) && (edge_o == '0)));                     // R5
  AST_EDGE_ON_OPEN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o & fix_o) == '0);                                        // R5
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));                                 // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);                                            // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);                                            // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (error_o && !accepted) |=> error_o);                            // R7
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> !error_o);                                         // R7
  AST_FAIL_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (error_o && !accepted) |=> $stable(fail_phase_o));              // R8
endmodule

bind path_delay_phase_ctrl pdt_checker #(
  .N_PATHS (N_PATHS),
  .N_PHASES(N_PHASES)
) i_pdt_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .fix_o       (fix_o),
  .edge_o      (edge_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .error_o     (error_o),
  .fail_phase_o(fail_phase_o)
);

// File: tb/test_path_delay_phase_ctrl.sv
`timescale 1ns/1ps
module test_path_delay_phase_ctrl;
  localparam int NP  = 8;
  localparam int NPH = 5;
  localparam int S   = 3;
  localparam int L   = S + 2;
  localparam logic [NP-1:0] PAR = 8'b1011_0110;

  // paths 0..6 open in phase (p mod 5); path 7 is never opened
  function automatic logic [NP-1:0] live_of(int k);
    logic [NP-1:0] m;
    m = '0;
    for (int p = 0; p < NP - 1; p++) if ((p % NPH) == k) m[p] = 1'b1;
    return m;
  endfunction

  function automatic logic [NPH*NP-1:0] mk_map();
    logic [NPH*NP-1:0] m;
    for (int k = 0; k < NPH; k++) m[k*NP +: NP] = live_of(k);
    return m;
  endfunction

  localparam logic [NPH*NP-1:0] MAP = mk_map();

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [NP-1:0] sink_i;
  logic [NP-1:0] fix_o, edge_o;
  logic          busy_o, done_o, error_o;
  logic [2:0]    fail_phase_o;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  logic [NP-1:0] slow = '0;
  logic [NP-1:0] prev_in = '0;
  logic [NP-1:0] path_in;

  always #10 clk = ~clk;

  path_delay_phase_ctrl #(
    .N_PATHS(NP), .N_PHASES(NPH), .SETTLE_CYC(S),
    .OFFPATH_PAR(PAR), .PHASE_MAP(MAP)
  ) i_path_delay_phase_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sink_i(sink_i),
    .fix_o(fix_o), .edge_o(edge_o), .busy_o(busy_o), .done_o(done_o),
    .error_o(error_o), .fail_phase_o(fail_phase_o)
  );

  // replicated path model: chain of pinnable XOR lookups, optionally one cycle late
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      logic s1, s2;
      s1 = fix_o[p] ? 1'b0 : (PAR[p] ^ edge_o[p]);
      s2 = fix_o[p] ? 1'b0 : (s1 ^ 1'b0);
      path_in[p] = fix_o[p] ? 1'b0 : (s2 ^ 1'b0);
    end
  end

  always_ff @(posedge clk) begin
    prev_in <= path_in;
    sink_i  <= (slow & prev_in) | (~slow & path_in);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_run(input logic [NP-1:0] slow_set, input bit exp_err,
                        input int exp_ph, input bit poke);
    slow = slow_set;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R7 error cleared after accepted start", {31'd0, error_o}, 32'd0);
    for (int t = 0; t < 2 * NPH * L; t++) begin
      int ph, pass, pos;
      logic lv;
      ph   = t / (2 * L);
      pass = (t / L) % 2;
      pos  = t % L;
      lv   = (pos < S) ? pass[0] : ~pass[0];
      if (t > 0) @(negedge clk);
      chk("R2 busy during run", {31'd0, busy_o}, 32'd1);
      chk("R3 fix pattern of phase", {24'd0, fix_o}, {24'd0, ~live_of(ph)});
      chk("R4 R5 edge level on open paths", {24'd0, edge_o}, {24'd0, live_of(ph) & {NP{lv}}});
      if (poke && t == 7) start_i = 1'b1;
      else start_i = 1'b0;
    end
    @(negedge clk);
    start_i = 1'b0;
    chk("R9 done pulse after last phase", {31'd0, done_o}, 32'd1);
    chk("R9 busy low with done", {31'd0, busy_o}, 32'd0);
    chk("R6 R7 error flag", {31'd0, error_o}, {31'd0, exp_err});
    if (exp_err) chk("R8 first failing phase", {29'd0, fail_phase_o}, exp_ph);
    @(negedge clk);
    chk("R9 done single cycle", {31'd0, done_o}, 32'd0);
    chk("R5 idle pins all paths", {24'd0, fix_o}, 32'hFF);
    chk("R7 error still held while idle", {31'd0, error_o}, {31'd0, exp_err});
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", {31'd0, busy_o}, 32'd0);
    chk("R1 reset done", {31'd0, done_o}, 32'd0);
    chk("R1 reset error", {31'd0, error_o}, 32'd0);
    chk("R1 reset fail phase", {29'd0, fail_phase_o}, 32'd0);
    chk("R1 reset fix", {24'd0, fix_o}, 32'hFF);
    chk("R1 reset edge", {24'd0, edge_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // clean run, with a start pulse mid-run that must be ignored (R2)
    do_run(8'h00, 1'b0, 0, 1'b1);
    // slow path that is never opened: R6 pinned sinks ignored
    do_run(8'h80, 1'b0, 0, 1'b0);
    // slow paths in phases 2 and 4: first fault at phase 2 (R8)
    do_run(8'h14, 1'b1, 2, 1'b0);
    // slow path only in last phase
    do_run(8'h10, 1'b1, 4, 1'b0);
    // slow path in first phase
    do_run(8'h01, 1'b1, 0, 1'b0);
    // clean run after errors: cleared by start (R7)
    do_run(8'h00, 1'b0, 0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule